// File: doc/BRIEF.md
# Stereo Gain, Mute and Silence Detector

This block sits in the sample path of a stereo audio stream. Each accepted frame carries one signed left sample and one signed right sample. Each channel is scaled by its own linear gain, and the scaled result is rounded and limited to the sample width. The two channels can also be inverted in polarity together.

The gain that is applied does not jump to a new setting. It walks toward its target by one step for every accepted frame, so a change of volume gives no audible click. A mute works the same way. Either the soft mute control or the hardware mute input sets the target of both channels to zero, and the gain then ramps down to it.

A separate watcher raises a flag when both inputs have stayed at zero for a long run of frames. A downstream stage can use this flag to power down or to switch an output off.

Top module: `stereo_gain_stage`

## Requirements
- R1: Each channel takes its own unsigned GAIN_W-bit volume word (14 bits by default). The word's value is the channel's target gain in units of 1/2^GAIN_W, except that the all-ones word targets exactly unity (2^GAIN_W).
- R2: After synchronous reset, both effective gains are unity, `out_vld` is 0, both outputs are 0 and `zero_flag` is 0.
- R3: On every frame with `in_vld` high, each effective gain moves exactly one step toward its target, or stays put if it is already there. Without `in_vld` the gains do not change.
- R4: One cycle after a frame with `in_vld` high, `out_vld` is 1 for one cycle. Each output is round-half-up(sample × gain / 2^GAIN_W), where gain is the value the channel's effective gain held before that frame's step.
- R5: While `soft_mute` or `mute_pin` is high, the target of both channels is 0. Once a gain has reached 0, that channel's output is 0 for any input.
- R6: When `invert` is high, both scaled outputs are negated. The result is limited to the range -2^(DATA_W-1) to 2^(DATA_W-1)-1, so a full-scale negative input at unity gain gives the largest positive code.
- R7: `zero_flag` goes high one cycle after the accepted frame that completes a run of ZERO_RUN+1 consecutive frames in which both samples are zero. It stays high while such frames continue.
- R8: A frame with a nonzero sample on either channel clears `zero_flag` one cycle later and restarts the run count from zero.
- R9: Cycles with `in_vld` low leave the outputs, `zero_flag` and the run count unchanged, and drive `out_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Strobe for an input frame |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| vol_left | input | GAIN_W | Left volume word |
| vol_right | input | GAIN_W | Right volume word |
| soft_mute | input | 1 | Control-bit mute, active high |
| mute_pin | input | 1 | Hardware mute, active high |
| invert | input | 1 | Polarity inversion of both outputs |
| out_vld | output | 1 | Output frame strobe |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| zero_flag | output | 1 | Sustained silence on both channels |

## Verification
The bench builds the block with DATA_W=8, GAIN_W=4 and ZERO_RUN=8. This makes it possible to sweep all 256 input codes against every reachable gain level, for both polarities, and to compare each result with a rounding and clamping formula computed in the bench. With 16 gain steps, a full ramp up or down, and the step-by-step response to a mute, can be walked frame by frame. A zero run of nine frames puts both the edge where the flag sets and the edge where it clears on nonzero data into a short sequence.

// File: rtl/gain_stage_pkg.sv
package gain_stage_pkg;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    typedef struct packed {
        logic       silence;
        logic       flip;
    } shared_ctl_t;

    function automatic ramp_dir_e pick_dir(input int unsigned cur, input int unsigned tgt);
        if (cur < tgt)      return RAMP_UP;
        else if (cur > tgt) return RAMP_DOWN;
        else                return RAMP_HOLD;
    endfunction

endpackage

// File: rtl/gain_ramp.sv
module gain_ramp
    import gain_stage_pkg::*;
#(
    parameter int GAIN_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [GAIN_W-1:0] vol,
    input  logic              silence,
    output logic [GAIN_W:0]   gain
);
    localparam logic [GAIN_W:0] UNITY = {1'b1, {GAIN_W{1'b0}}};
    localparam logic [GAIN_W:0] ONE   = {{GAIN_W{1'b0}}, 1'b1};

    logic [GAIN_W:0] target;
    ramp_dir_e       dir;

    always_comb begin
        if (silence)   target = '0;
        else if (&vol) target = UNITY;
        else           target = {1'b0, vol};
        dir = pick_dir(int'(gain), int'(target));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= UNITY;
        end else if (step) begin
            case (dir)
                RAMP_UP:   gain <= gain + ONE;
                RAMP_DOWN: gain <= gain - ONE;
                default:   gain <= gain;
            endcase
        end
    end
endmodule

// File: rtl/frame_scaler.sv
module frame_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] sample,
    input  logic [GAIN_W:0]   gain,
    input  logic              flip,
    output logic [DATA_W-1:0] result
);
    localparam int PW = DATA_W + GAIN_W + 2;
    localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (GAIN_W - 1);
    localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PW-1:0] xs, gs, prod, scaled, signed_v, limited;

    always_comb begin
        xs       = {{(PW-DATA_W){sample[DATA_W-1]}}, sample};
        gs       = {{(PW-GAIN_W-1){1'b0}}, gain};
        prod     = xs * gs;
        scaled   = (prod + HALF) >>> GAIN_W;
        signed_v = flip ? -scaled : scaled;
        if (signed_v > MAXV)      limited = MAXV;
        else if (signed_v < MINV) limited = MINV;
        else                      limited = signed_v;
    end

    always_ff @(posedge clk) begin
        if (rst)       result <= '0;
        else if (load) result <= limited[DATA_W-1:0];
    end
endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
    parameter int DATA_W   = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    output logic              flag
);
    localparam int CNT_W = $clog2(ZERO_RUN + 2);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN + 1);

    logic [CNT_W-1:0] run_q, run_n;
    logic             quiet;

    always_comb begin
        quiet = (left == '0) && (right == '0);
        if (!quiet)             run_n = '0;
        else if (run_q < LIMIT) run_n = run_q + 1'b1;
        else                    run_n = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            flag  <= 1'b0;
        end else if (load) begin
            run_q <= run_n;
            flag  <= (run_n == LIMIT);
        end
    end
endmodule

// File: rtl/stereo_gain_stage.sv
module stereo_gain_stage
    import gain_stage_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 14,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [GAIN_W-1:0] vol_left,
    input  logic [GAIN_W-1:0] vol_right,
    input  logic              soft_mute,
    input  logic              mute_pin,
    input  logic              invert,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              zero_flag
);
    localparam int NCH = 2;

    shared_ctl_t       ctl;
    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];
    logic [GAIN_W-1:0] ch_vol [NCH];
    logic [GAIN_W:0]   ch_gain[NCH];
    logic [GAIN_W:0]   gain_l, gain_r;

    always_comb begin
        ctl.silence = soft_mute | mute_pin;
        ctl.flip    = invert;
        ch_in[0]    = in_left;
        ch_in[1]    = in_right;
        ch_vol[0]   = vol_left;
        ch_vol[1]   = vol_right;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
            .clk    (clk),
            .rst    (rst),
            .step   (in_vld),
            .vol    (ch_vol[c]),
            .silence(ctl.silence),
            .gain   (ch_gain[c])
        );
        frame_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
            .clk    (clk),
            .rst    (rst),
            .load   (in_vld),
            .sample (ch_in[c]),
            .gain   (ch_gain[c]),
            .flip   (ctl.flip),
            .result (ch_out[c])
        );
    end

    zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk  (clk),
        .rst  (rst),
        .load (in_vld),
        .left (in_left),
        .right(in_right),
        .flag (zero_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= in_vld;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];
    assign gain_l    = ch_gain[0];
    assign gain_r    = ch_gain[1];
endmodule

// File: rtl/stereo_gain_stage_chk.sv
module stereo_gain_stage_chk #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [DATA_W-1:0] in_left,
    input logic [DATA_W-1:0] in_right,
    input logic              soft_mute,
    input logic              mute_pin,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              zero_flag,
    input logic [GAIN_W:0]   gain_l,
    input logic [GAIN_W:0]   gain_r
);
    localparam logic [GAIN_W:0] UNITY = {1'b1, {GAIN_W{1'b0}}};

    assert_reset_unity_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gain_l == UNITY && gain_r == UNITY));

    assert_gain_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        gain_l <= UNITY && gain_r <= UNITY);

    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ({1'b0, gain_l} == {1'b0, $past(gain_l)} + 1'b1 ||
                    {1'b0, gain_l} + 1'b1 == {1'b0, $past(gain_l)} ||
                    gain_l == $past(gain_l)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(gain_l) && $stable(gain_r));

    assert_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld && $stable(out_left) && $stable(zero_flag));

    assert_mute_falls_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (soft_mute || mute_pin) && gain_l != '0) |=>
            ({1'b0, gain_l} + 1'b1 == {1'b0, $past(gain_l)}));

    assert_mute_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && gain_l == '0 && gain_r == '0) |=> (out_left == '0 && out_right == '0));

    assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag) |-> $past(in_vld && in_left == '0 && in_right == '0));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (in_left != '0 || in_right != '0)) |=> !zero_flag);
endmodule

bind stereo_gain_stage stereo_gain_stage_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_left  (in_left),
    .in_right (in_right),
    .soft_mute(soft_mute),
    .mute_pin (mute_pin),
    .out_vld  (out_vld),
    .out_left (out_left),
    .out_right(out_right),
    .zero_flag(zero_flag),
    .gain_l   (gain_l),
    .gain_r   (gain_r)
);

// File: tb/stereo_gain_stage_tb.sv
module stereo_gain_stage_tb;
    localparam int DW   = 8;
    localparam int GW   = 4;
    localparam int ZRUN = 8;
    localparam int UNIT = 1 << GW;
    localparam int VMAX = UNIT - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic [GW-1:0] vol_left = GW'(VMAX), vol_right = GW'(VMAX);
    logic          soft_mute = 1'b0, mute_pin = 1'b0, invert = 1'b0;
    logic          out_vld;
    logic [DW-1:0] out_left, out_right;
    logic          zero_flag;

    int nchk = 0;
    int nerr = 0;
    int mg_l = UNIT, mg_r = UNIT, zc = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    stereo_gain_stage #(.DATA_W(DW), .GAIN_W(GW), .ZERO_RUN(ZRUN)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_left(in_left), .in_right(in_right),
        .vol_left(vol_left), .vol_right(vol_right), .soft_mute(soft_mute),
        .mute_pin(mute_pin), .invert(invert), .out_vld(out_vld),
        .out_left(out_left), .out_right(out_right), .zero_flag(zero_flag)
    );

    task automatic chk(input string tag, input int act, input int exp_v);
        nchk++;
        if (act != exp_v) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp_v);
        end
    endtask

    function automatic int expect_out(input int x, input int g, input logic inv);
        int s;
        s = (x * g + (UNIT / 2)) >>> GW;
        if (inv) s = -s;
        if (s > (1 << (DW - 1)) - 1) s = (1 << (DW - 1)) - 1;
        if (s < -(1 << (DW - 1)))    s = -(1 << (DW - 1));
        return s;
    endfunction

    function automatic int tgt(input int v);
        if (soft_mute || mute_pin) return 0;
        return (v == VMAX) ? UNIT : v;
    endfunction

    function automatic int stepg(input int g, input int t);
        if (g < t) return g + 1;
        if (g > t) return g - 1;
        return g;
    endfunction

    task automatic frame(input int l, input int r, input string tag);
        int el, er;
        el = expect_out(l, mg_l, invert);
        er = expect_out(r, mg_r, invert);
        mg_l = stepg(mg_l, tgt(int'(vol_left)));
        mg_r = stepg(mg_r, tgt(int'(vol_right)));
        if (l == 0 && r == 0) zc = (zc < ZRUN + 1) ? zc + 1 : zc;
        else                  zc = 0;
        @(negedge clk);
        in_vld   = 1'b1;
        in_left  = DW'(l);
        in_right = DW'(r);
        @(negedge clk);
        in_vld = 1'b0;
        chk({tag, " out_vld R4"}, int'(out_vld), 1);
        chk({tag, " left"}, int'($signed(out_left)), el);
        chk({tag, " right"}, int'($signed(out_right)), er);
        chk({tag, " zero_flag R7 R8"}, int'(zero_flag), (zc > ZRUN) ? 1 : 0);
    endtask

    task automatic settle(input string tag);
        for (int k = 0; k < UNIT + 2; k++) frame(100, -77, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk("reset out_vld R2", int'(out_vld), 0);
        chk("reset out_left R2", int'(out_left), 0);
        chk("reset flag R2", int'(zero_flag), 0);
        // R2: unity straight after reset
        frame(-128, 127, "unity after reset R2");
        // R9: idle cycles hold outputs
        repeat (3) @(negedge clk);
        chk("idle out_vld R9", int'(out_vld), 0);
        chk("idle left hold R9", int'($signed(out_left)), -128);
        // R3: ramp down one step per frame from unity to 3
        vol_left = GW'(3); vol_right = GW'(12);
        for (int k = 0; k < 16; k++) frame(127, -128, "ramp R3");
        // R3: idle cycles do not move gain
        repeat (5) @(negedge clk);
        frame(127, 127, "gain held across idle R3 R9");
        // R1 R4 R6: exhaustive sweep over gain levels, polarities and codes
        for (int v = 0; v <= VMAX; v++) begin
            for (int p = 0; p < 2; p++) begin
                invert = p[0];
                vol_left = GW'(v); vol_right = GW'(VMAX - v);
                settle("settle R3");
                for (int x = -128; x < 128; x++)
                    frame(x, -1 - x, p ? "sweep inverted R6" : "sweep R1 R4");
            end
        end
        invert = 1'b0;
        // R6: saturation of the negated full-scale input
        vol_left = GW'(VMAX); vol_right = GW'(VMAX);
        settle("settle R6");
        invert = 1'b1;
        frame(-128, 0, "saturate R6");
        invert = 1'b0;
        // R5: soft mute ramps down and silences
        soft_mute = 1'b1;
        for (int k = 0; k < UNIT + 2; k++) frame(127, -128, "soft mute R5");
        frame(-128, 127, "muted silent R5");
        chk("muted left zero R5", int'(out_left), 0);
        soft_mute = 1'b0;
        for (int k = 0; k < UNIT + 2; k++) frame(127, -128, "unmute ramp R3");
        // R5: hardware mute pin
        mute_pin = 1'b1;
        for (int k = 0; k < UNIT + 2; k++) frame(-100, 90, "pin mute R5");
        chk("pin muted right zero R5", int'(out_right), 0);
        mute_pin = 1'b0;
        settle("settle after pin");
        // R7: flag at the run boundary
        for (int k = 0; k < ZRUN + 4; k++) frame(0, 0, "zero run R7");
        chk("flag set R7", int'(zero_flag), 1);
        // R8: nonzero on right clears, run restarts
        frame(0, 1, "clear R8");
        chk("flag cleared R8", int'(zero_flag), 0);
        for (int k = 0; k < ZRUN; k++) frame(0, 0, "rerun R8");
        chk("flag still low at boundary R8", int'(zero_flag), 0);
        frame(0, 0, "rerun last R7");
        chk("flag set again R7", int'(zero_flag), 1);
        frame(-1, 0, "clear left R8");
        // R9: idle cycles keep flag and count
        for (int k = 0; k < ZRUN; k++) frame(0, 0, "partial run R9");
        repeat (4) @(negedge clk);
        frame(0, 0, "run across idle R9");
        chk("flag after idle gap R9", int'(zero_flag), 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule